// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block is the host-side engine for an 8-bit asynchronous small-page NAND device. A request names an operation (page read, page program, block erase, status read or identification read) with a row address, a column address and a byte count. The sequencer then drives the chip-enable, command-latch, address-latch, write-strobe and read-strobe pins and the bidirectional data bus through the exact sequence that operation needs. Payload bytes enter through a valid/ready write stream and leave through a valid/ready read stream. A one-cycle result pulse reports whether the operation succeeded.

Every bus cycle has a strobe-low phase and a strobe-high phase, each lasting a whole number of system clocks set by parameters. Two-step operations (program, erase) send a setup command, then addresses (and data for a program), then a confirm command. The block then waits for the ready/busy line to return high and reads the status byte, whose bit 0 marks a failure. During the wait the busy line is ignored for a guard window, and a timeout limit bounds the wait.

Top module: `nand_cmd_seq`

## Requirements
- R1: While reset is held and after it is released, `nandCeN`, `nandWeN` and `nandReN` are high, `nandCle`, `nandAle` and `nandDqOe` are low, `reqReady` is high and `rdValid` and `resValid` are low.
- R2: Each byte the device latches is presented with `nandCle`=1/`nandAle`=0 for a command, `nandAle`=1/`nandCle`=0 for an address and both low for data. `nandWeN` is low for exactly PHASE_LO clocks, with `nandDqOe` high and `nandCeN` low. `nandWeN` and `nandReN` are never low together.
- R3: Page read (`reqOp`=0) sends command 00h, 01h or 50h for `reqArea` 1→01h, 2→50h and any other value→00h. It then sends address bytes column, row[7:0], row[15:8], waits for ready, and performs `reqLen` read-strobe cycles, clamped to 528. The bytes appear on the read stream in order, and the result reports no failure.
- R4: Page program (`reqOp`=1) sends 80h, the three address bytes, `reqLen` data bytes taken in order from the write stream, then 10h. After ready it sends 70h and performs one read cycle. `resStatus` is that byte and `resFail` equals its bit 0.
- R5: Block erase (`reqOp`=2) sends 60h, row[7:0], row[15:8] and D0h. After ready it reads status as in R4.
- R6: Status read (`reqOp`=3, and also any `reqOp` value of 5 to 7) sends 70h and performs one read cycle. `resStatus` is the byte and `resFail` is its bit 0.
- R7: ID read (`reqOp`=4) sends 90h and one address byte 00h, then performs two read cycles that both appear on the read stream. `resFail` is set unless the bytes are ECh followed by 73h.
- R8: If the ready/busy input has not been seen high within TMO_LIMIT clocks of the start of a wait, the operation ends with `resFail`=1 and `resTimeout`=1. No status command is sent, and `nandCeN` returns high.
- R9: While `rdValid` is high and `rdReady` is low, `rdData` holds and no further read strobe starts. The number of read strobes equals the number of bytes delivered.
- R10: Every accepted request yields exactly one single-cycle `resValid` pulse. `reqReady` is low from acceptance until the pulse and high again after it.
- R11: For the first GUARD clocks of a wait the ready/busy input is ignored. The status command or first data read therefore comes only after the device's busy period has ended, even when busy starts several clocks after the last strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Sequencer idle, request accepted |
| reqOp | input | 3 | 0 read, 1 program, 2 erase, 3 status, 4 ID |
| reqArea | input | 2 | Read pointer region select |
| reqCol | input | 8 | Column address byte |
| reqRow | input | 16 | Row address |
| reqLen | input | 10 | Byte count (default page size) |
| wrValid | input | 1 | Write-stream byte offered |
| wrReady | output | 1 | Write-stream byte taken |
| wrData | input | 8 | Write-stream byte |
| rdValid | output | 1 | Read-stream byte available |
| rdReady | input | 1 | Read-stream byte taken |
| rdData | output | 8 | Read-stream byte |
| resValid | output | 1 | Result pulse |
| resFail | output | 1 | Operation failed |
| resTimeout | output | 1 | Busy wait exceeded the limit |
| resStatus | output | 8 | Status byte read back |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandDqOut | output | 8 | Bus output value |
| nandDqOe | output | 1 | Bus output enable |
| nandDqIn | input | 8 | Bus input value |
| nandRbIn | input | 1 | Ready (1) / busy (0) |

## Verification
The hardest case to reach is a device that pulls busy low several clocks after the confirm strobe has already risen. A sequencer without a guard window would read the still-high line as "done" and send the status command too early. The bench's device model therefore delays its busy assertion by six clocks after each trigger. It checks that the status command or first read strobe is latched after the recorded busy release. A second hard case is a device that never becomes ready. The model holds busy low indefinitely for one program operation, so the timeout path is forced and the bench confirms that no status command follows.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_PROG   = 3'd1,
    OP_ERASE  = 3'd2,
    OP_STATUS = 3'd3,
    OP_ID     = 3'd4
  } nandOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       startWr;
    logic       startRd;
    logic       cle;
    logic       ale;
    logic [7:0] txByte;
    logic       waitClr;
    logic       selOn;
  } seqStrobe_t;

  localparam logic [7:0] CMD_RD_LOW     = 8'h00;
  localparam logic [7:0] CMD_RD_HIGH    = 8'h01;
  localparam logic [7:0] CMD_RD_SPARE   = 8'h50;
  localparam logic [7:0] CMD_PROG_SETUP = 8'h80;
  localparam logic [7:0] CMD_PROG_GO    = 8'h10;
  localparam logic [7:0] CMD_ERASE_SET  = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO   = 8'hD0;
  localparam logic [7:0] CMD_STATUS     = 8'h70;
  localparam logic [7:0] CMD_IDENT      = 8'h90;
  localparam logic [7:0] ID_MAKER       = 8'hEC;
  localparam logic [7:0] ID_PART        = 8'h73;

endpackage

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int PHASE_LO  = 2,
  parameter int PHASE_HI  = 2,
  parameter int GUARD     = 8,
  parameter int TMO_LIMIT = 100000
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  output logic       cycDone,
  output logic [7:0] rxByte,
  output logic       rbReady,
  output logic       tmoHit,
  output logic       ceN,
  output logic       cle,
  output logic       ale,
  output logic       weN,
  output logic       reN,
  output logic [7:0] dqOut,
  output logic       dqOe,
  input  logic [7:0] dqIn,
  input  logic       rbIn
);

  localparam int PMAX = (PHASE_LO > PHASE_HI) ? PHASE_LO : PHASE_HI;
  localparam int PW   = $clog2(PMAX + 1);
  localparam int TW   = $clog2(TMO_LIMIT + 1);

  logic          active, lowPhase, isRead;
  logic [PW-1:0] phCnt;
  logic [1:0]    rbSync;
  logic [TW-1:0] waitCnt;

  // bus cycle engine: low phase, then high phase, then done pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      lowPhase <= 1'b0;
      isRead   <= 1'b0;
      phCnt    <= '0;
      weN      <= 1'b1;
      reN      <= 1'b1;
      cle      <= 1'b0;
      ale      <= 1'b0;
      dqOut    <= '0;
      dqOe     <= 1'b0;
      rxByte   <= '0;
      cycDone  <= 1'b0;
      ceN      <= 1'b1;
    end else begin
      cycDone <= 1'b0;
      ceN     <= !strb.selOn;
      if (!active) begin
        if (strb.startWr || strb.startRd) begin
          active   <= 1'b1;
          lowPhase <= 1'b1;
          isRead   <= strb.startRd;
          phCnt    <= PW'(PHASE_LO - 1);
          weN      <= !strb.startWr;
          reN      <= !strb.startRd;
          cle      <= strb.cle;
          ale      <= strb.ale;
          dqOut    <= strb.txByte;
          dqOe     <= strb.startWr;
        end
      end else if (phCnt != '0) begin
        phCnt <= phCnt - 1'b1;
      end else if (lowPhase) begin
        lowPhase <= 1'b0;
        phCnt    <= PW'(PHASE_HI - 1);
        weN      <= 1'b1;
        reN      <= 1'b1;
        if (isRead) rxByte <= dqIn;
      end else begin
        active  <= 1'b0;
        cycDone <= 1'b1;
        cle     <= 1'b0;
        ale     <= 1'b0;
        dqOe    <= 1'b0;
      end
    end
  end

  // busy-line synchroniser and shared guard/timeout counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rbSync  <= 2'b11;
      waitCnt <= '0;
    end else begin
      rbSync <= {rbSync[0], rbIn};
      if (strb.waitClr)                 waitCnt <= '0;
      else if (waitCnt != TW'(TMO_LIMIT)) waitCnt <= waitCnt + 1'b1;
    end
  end

  assign rbReady = (waitCnt >= TW'(GUARD)) && rbSync[1];
  assign tmoHit  = (waitCnt == TW'(TMO_LIMIT)) && !rbSync[1];

  // R2
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(cle && ale));
  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(!weN && !reN));
  // R2
  we_drive_chk: assert property (@(posedge clk) disable iff (!rstN) !weN |-> dqOe);
  // R2
  sel_cover_chk: assert property (@(posedge clk) disable iff (!rstN) (!weN || !reN) |-> !ceN);

endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 528,
  parameter int LW         = $clog2(PAGE_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [2:0]    reqOp,
  input  logic [1:0]    reqArea,
  input  logic [7:0]    reqCol,
  input  logic [15:0]   reqRow,
  input  logic [LW-1:0] reqLen,
  input  logic          wrValid,
  output logic          wrReady,
  input  logic [7:0]    wrData,
  output logic          rdValid,
  input  logic          rdReady,
  output logic [7:0]    rdData,
  output logic          resValid,
  output logic          resFail,
  output logic          resTimeout,
  output logic [7:0]    resStatus,
  output seqStrobe_t    strb,
  input  logic          cycDone,
  input  logic [7:0]    rxByte,
  input  logic          rbReady,
  input  logic          tmoHit
);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_ADDR, S_WDATA, S_CONF, S_WAIT,
    S_RDATA, S_RHOLD, S_SCMD, S_SRD, S_DONE
  } seqState_e;

  seqState_e     st;
  nandOp_e       op;
  logic [1:0]    area;
  logic [7:0]    col;
  logic [15:0]   row;
  logic [LW-1:0] left;
  logic [1:0]    addrIdx;
  logic          inFlight, idSecond, failQ, tmoQ;
  logic [7:0]    statQ;
  logic [7:0]    cmdByte, addrByte, confByte;
  logic          lastAddr, issue;

  always_comb begin
    case (op)
      OP_READ:  cmdByte = (area == 2'd1) ? CMD_RD_HIGH :
                          (area == 2'd2) ? CMD_RD_SPARE : CMD_RD_LOW;
      OP_PROG:  cmdByte = CMD_PROG_SETUP;
      OP_ERASE: cmdByte = CMD_ERASE_SET;
      OP_ID:    cmdByte = CMD_IDENT;
      default:  cmdByte = CMD_STATUS;
    endcase
    case (addrIdx)
      2'd0:    addrByte = (op == OP_ID) ? 8'h00 : col;
      2'd1:    addrByte = row[7:0];
      default: addrByte = row[15:8];
    endcase
    confByte = (op == OP_PROG) ? CMD_PROG_GO : CMD_ERASE_GO;
    lastAddr = (op == OP_ID) ? (addrIdx == 2'd0) : (addrIdx == 2'd2);
  end

  assign issue = !inFlight;

  always_comb begin
    strb         = '0;
    strb.selOn   = (st != S_IDLE) && (st != S_DONE);
    strb.waitClr = (st != S_WAIT);
    case (st)
      S_CMD:   begin strb.startWr = issue; strb.cle = 1'b1; strb.txByte = cmdByte;    end
      S_ADDR:  begin strb.startWr = issue; strb.ale = 1'b1; strb.txByte = addrByte;   end
      S_WDATA: begin strb.startWr = issue && wrValid;      strb.txByte = wrData;      end
      S_CONF:  begin strb.startWr = issue; strb.cle = 1'b1; strb.txByte = confByte;   end
      S_SCMD:  begin strb.startWr = issue; strb.cle = 1'b1; strb.txByte = CMD_STATUS; end
      S_RDATA, S_SRD: strb.startRd = issue;
      default: ;
    endcase
  end

  assign reqReady   = (st == S_IDLE);
  assign wrReady    = (st == S_WDATA) && !inFlight;
  assign rdValid    = (st == S_RHOLD);
  assign rdData     = rxByte;
  assign resValid   = (st == S_DONE);
  assign resFail    = failQ;
  assign resTimeout = tmoQ;
  assign resStatus  = statQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= S_IDLE;
      op       <= OP_STATUS;
      area     <= '0;
      col      <= '0;
      row      <= '0;
      left     <= '0;
      addrIdx  <= '0;
      inFlight <= 1'b0;
      idSecond <= 1'b0;
      failQ    <= 1'b0;
      tmoQ     <= 1'b0;
      statQ    <= '0;
    end else begin
      if (strb.startWr || strb.startRd) inFlight <= 1'b1;
      else if (cycDone)                 inFlight <= 1'b0;
      case (st)
        S_IDLE: if (reqValid) begin
          op       <= (reqOp > 3'd4) ? OP_STATUS : nandOp_e'(reqOp);
          area     <= reqArea;
          col      <= reqCol;
          row      <= reqRow;
          left     <= (reqLen > LW'(PAGE_BYTES)) ? LW'(PAGE_BYTES) : reqLen;
          failQ    <= 1'b0;
          tmoQ     <= 1'b0;
          statQ    <= '0;
          idSecond <= 1'b0;
          st       <= S_CMD;
        end
        S_CMD: if (cycDone) begin
          addrIdx <= (op == OP_ERASE) ? 2'd1 : 2'd0;
          st      <= (op == OP_STATUS) ? S_SRD : S_ADDR;
        end
        S_ADDR: if (cycDone) begin
          if (!lastAddr) addrIdx <= addrIdx + 2'd1;
          else begin
            case (op)
              OP_READ:  st <= S_WAIT;
              OP_PROG:  st <= (left == '0) ? S_CONF : S_WDATA;
              OP_ERASE: st <= S_CONF;
              default:  begin left <= LW'(2); st <= S_RDATA; end
            endcase
          end
        end
        S_WDATA: if (cycDone) begin
          left <= left - 1'b1;
          if (left == LW'(1)) st <= S_CONF;
        end
        S_CONF: if (cycDone) st <= S_WAIT;
        S_WAIT: begin
          if (tmoHit) begin
            failQ <= 1'b1;
            tmoQ  <= 1'b1;
            st    <= S_DONE;
          end else if (rbReady) begin
            if (op == OP_READ) st <= (left == '0) ? S_DONE : S_RDATA;
            else               st <= S_SCMD;
          end
        end
        S_RDATA: if (cycDone) st <= S_RHOLD;
        S_RHOLD: if (rdReady) begin
          left <= left - 1'b1;
          if (op == OP_ID) begin
            idSecond <= 1'b1;
            if (rxByte != (idSecond ? ID_PART : ID_MAKER)) failQ <= 1'b1;
          end
          st <= (left == LW'(1)) ? S_DONE : S_RDATA;
        end
        S_SCMD: if (cycDone) st <= S_SRD;
        S_SRD: if (cycDone) begin
          statQ <= rxByte;
          failQ <= rxByte[0];
          st    <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) resValid |=> !resValid);
  // R10
  accept_chk: assert property (@(posedge clk) disable iff (!rstN) (reqValid && reqReady) |=> !reqReady);
  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData)));
  // R8
  tmo_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((st == S_WAIT) && tmoHit) |=> (resValid && resTimeout && resFail));

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int PHASE_LO   = 2,
  parameter int PHASE_HI   = 2,
  parameter int GUARD      = 8,
  parameter int TMO_LIMIT  = 100000,
  parameter int PAGE_BYTES = 528,
  parameter int LW         = $clog2(PAGE_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [2:0]    reqOp,
  input  logic [1:0]    reqArea,
  input  logic [7:0]    reqCol,
  input  logic [15:0]   reqRow,
  input  logic [LW-1:0] reqLen,
  input  logic          wrValid,
  output logic          wrReady,
  input  logic [7:0]    wrData,
  output logic          rdValid,
  input  logic          rdReady,
  output logic [7:0]    rdData,
  output logic          resValid,
  output logic          resFail,
  output logic          resTimeout,
  output logic [7:0]    resStatus,
  output logic          nandCeN,
  output logic          nandCle,
  output logic          nandAle,
  output logic          nandWeN,
  output logic          nandReN,
  output logic [7:0]    nandDqOut,
  output logic          nandDqOe,
  input  logic [7:0]    nandDqIn,
  input  logic          nandRbIn
);

  seqStrobe_t strb;
  logic       cycDone, rbReady, tmoHit;
  logic [7:0] rxByte;

  nand_seq_ctrl #(.PAGE_BYTES(PAGE_BYTES), .LW(LW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp), .reqArea(reqArea),
    .reqCol(reqCol), .reqRow(reqRow), .reqLen(reqLen),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData),
    .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData),
    .resValid(resValid), .resFail(resFail), .resTimeout(resTimeout), .resStatus(resStatus),
    .strb(strb), .cycDone(cycDone), .rxByte(rxByte), .rbReady(rbReady), .tmoHit(tmoHit)
  );

  nand_seq_dp #(.PHASE_LO(PHASE_LO), .PHASE_HI(PHASE_HI), .GUARD(GUARD), .TMO_LIMIT(TMO_LIMIT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cycDone(cycDone), .rxByte(rxByte), .rbReady(rbReady), .tmoHit(tmoHit),
    .ceN(nandCeN), .cle(nandCle), .ale(nandAle), .weN(nandWeN), .reN(nandReN),
    .dqOut(nandDqOut), .dqOe(nandDqOe), .dqIn(nandDqIn), .rbIn(nandRbIn)
  );

endmodule

// File: tb/nand_cmd_seq_tb.sv
module nand_cmd_seq_tb;

  localparam int LW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic          reqValid = 0, wrValid = 0, rdReady = 0;
  logic [2:0]    reqOp = 0;
  logic [1:0]    reqArea = 0;
  logic [7:0]    reqCol = 0, wrData = 0;
  logic [15:0]   reqRow = 0;
  logic [LW-1:0] reqLen = 0;
  logic          reqReady, wrReady, rdValid, resValid, resFail, resTimeout;
  logic [7:0]    rdData, resStatus, nandDqOut, nandDqIn;
  logic          nandCeN, nandCle, nandAle, nandWeN, nandReN, nandDqOe;
  logic          nandRb = 1'b1;

  nand_cmd_seq #(.TMO_LIMIT(400)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqArea(reqArea), .reqCol(reqCol), .reqRow(reqRow), .reqLen(reqLen),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData),
    .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData),
    .resValid(resValid), .resFail(resFail), .resTimeout(resTimeout), .resStatus(resStatus),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
    .nandReN(nandReN), .nandDqOut(nandDqOut), .nandDqOe(nandDqOe),
    .nandDqIn(nandDqIn), .nandRbIn(nandRb)
  );

  int nChk = 0, nFail = 0;
  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pageByte(input int row, input int col, input int i);
    return 8'(row * 5 + col * 3 + i * 7 + (row >> 8));
  endfunction

  // ---------------- device model ----------------
  int cyc = 0;
  always @(posedge clk) cyc++;

  logic [7:0] logB [1024];
  int         logK [1024];
  int         logT [1024];
  int         logN = 0;
  logic [7:0] lastCmd = 8'hFF;
  logic [7:0] addrB [3];
  int  addrSeen = 0, rdPtr = 0, phaseErr = 0, weFall = 0, reFallT = 0;
  int  reFalls = 0, firstReCyc = 0, rbRiseCyc = 0;
  bit  reMark = 0, trigBusy = 0, busyLong = 0;
  int  bDelay = 0, bLow = 0;
  logic [7:0] statusVal = 8'h00, idB0 = 8'hEC, idB1 = 8'h73;

  always @(negedge nandWeN) if (rstN) weFall = cyc;
  always @(posedge nandWeN) if (rstN) begin
    if (cyc - weFall != 2 || nandCeN || !nandDqOe) phaseErr++;
    logB[logN] = nandDqOut;
    logK[logN] = (nandCle && nandAle) ? 3 : nandCle ? 0 : nandAle ? 1 : 2;
    logT[logN] = cyc;
    if (logN < 1023) logN++;
    if (nandCle) begin
      lastCmd = nandDqOut; addrSeen = 0; rdPtr = 0;
      if (nandDqOut == 8'h10 || nandDqOut == 8'hD0) trigBusy = 1;
    end else if (nandAle) begin
      if (addrSeen < 3) addrB[addrSeen] = nandDqOut;
      addrSeen++;
      if (addrSeen == 3 && (lastCmd == 8'h00 || lastCmd == 8'h01 || lastCmd == 8'h50)) trigBusy = 1;
    end
  end
  always @(negedge nandReN) if (rstN) begin
    reFalls++; reFallT = cyc;
    if (reMark) begin firstReCyc = cyc; reMark = 0; end
  end
  always @(posedge nandReN) if (rstN) begin
    if (cyc - reFallT != 2) phaseErr++;
    rdPtr++;
  end

  always @(posedge clk) begin
    if (trigBusy) begin trigBusy = 0; bDelay = 6; end
    else if (bDelay > 0) begin
      bDelay--;
      if (bDelay == 0) begin nandRb <= 1'b0; bLow = busyLong ? 1000000 : 30; end
    end else if (bLow > 0) begin
      bLow--;
      if (bLow == 0) begin nandRb <= 1'b1; rbRiseCyc = cyc; end
    end
  end

  assign nandDqIn = (lastCmd == 8'h70) ? statusVal :
                    (lastCmd == 8'h90) ? ((rdPtr == 0) ? idB0 : idB1) :
                    pageByte({addrB[2], addrB[1]}, addrB[0], rdPtr);

  // ---------------- request driver ----------------
  logic [7:0] wrBuf [600];
  logic [7:0] rdBuf [600];
  int rdN = 0, reStart = 0;
  bit gFail, gTmo;
  logic [7:0] gStat;
  logic [7:0] expB [600];
  int expK [600];
  int expN = 0;

  task automatic push(input int k, input logic [7:0] b);
    expB[expN] = b; expK[expN] = k; expN++;
  endtask

  task automatic runOp(input int op, input int area, input int col, input int row,
                       input int len, input bit bp, input int seed);
    int t = 0;
    int wrIdx = 0;
    bit wrHs = 0;
    for (int i = 0; i < 600; i++) wrBuf[i] = 8'(i * 11 + seed);
    logN = 0; rdN = 0; expN = 0; reStart = reFalls; reMark = 1;
    @(negedge clk);
    chk(reqReady, "R10", "ready before request", reqReady, 1);
    reqOp = 3'(op); reqArea = 2'(area); reqCol = 8'(col); reqRow = 16'(row);
    reqLen = LW'(len); reqValid = 1; wrValid = 1;
    @(negedge clk);
    reqValid = 0;
    forever begin
      if (wrHs) wrIdx++;
      wrData = wrBuf[wrIdx];
      wrHs = wrValid && wrReady;
      rdReady = bp ? (t % 3 == 2) : 1'b1;
      if (rdValid && rdReady) begin
        if (rdN < 600) rdBuf[rdN] = rdData;
        rdN++;
      end
      if (resValid) begin
        gFail = resFail; gTmo = resTimeout; gStat = resStatus;
        break;
      end
      @(negedge clk);
      t++;
      if (t > 20000) begin
        chk(0, "R10", "operation never finished", t, 0);
        break;
      end
    end
    wrValid = 0; rdReady = 0;
    @(negedge clk);
    chk(!resValid && reqReady, "R10", "single pulse and ready again", resValid, 0);
  endtask

  task automatic chkSeq(input string rq);
    bit ok = (logN == expN);
    int bad = -1;
    if (ok)
      for (int i = 0; i < expN; i++)
        if (logB[i] !== expB[i] || logK[i] != expK[i]) begin
          ok = 0;
          if (bad < 0) bad = i;
        end
    chk(ok, rq, "latched byte sequence", (bad < 0) ? logN : int'(logB[bad]),
        (bad < 0) ? expN : int'(expB[bad]));
  endtask

  task automatic doRead(input int area, input int col, input int row, input int len, input bit bp);
    int n = (len > 528) ? 528 : len;
    bit ok = 1;
    logic [7:0] c = (area == 1) ? 8'h01 : (area == 2) ? 8'h50 : 8'h00;
    runOp(0, area, col, row, len, bp, 0);
    push(0, c); push(1, 8'(col)); push(1, 8'(row)); push(1, 8'(row >> 8));
    chkSeq("R3");
    chk(rdN == n, "R3", "bytes delivered", rdN, n);
    for (int i = 0; i < n && i < rdN; i++) if (rdBuf[i] !== pageByte(row, col, i)) ok = 0;
    chk(ok, "R3", "read data pattern", rdN, n);
    chk(reFalls - reStart == n, "R9", "read strobes equal bytes", reFalls - reStart, n);
    chk(!gFail && !gTmo, "R3", "read result", gFail, 0);
    chk(firstReCyc > rbRiseCyc, "R11", "read strobe after busy release", firstReCyc, rbRiseCyc);
  endtask

  task automatic doStatusTail(input string rq, input logic [7:0] sv);
    chk(gStat == sv, rq, "status byte", gStat, sv);
    chk(gFail == sv[0] && !gTmo, rq, "fail from status bit 0", gFail, sv[0]);
    chk(logT[logN-1] > rbRiseCyc && rbRiseCyc > logT[logN-2], "R11",
        "status command after busy release", logT[logN-1], rbRiseCyc);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL R10 watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(nandCeN && nandWeN && nandReN && !nandCle && !nandAle && !nandDqOe, "R1",
        "pins in reset", {nandCeN, nandWeN, nandReN, nandCle, nandAle, nandDqOe}, 6'b111000);
    rstN = 1;
    repeat (2) @(negedge clk);
    chk(nandCeN && nandWeN && nandReN && !nandCle && !nandAle && !nandDqOe, "R1",
        "pins after reset", {nandCeN, nandWeN, nandReN, nandCle, nandAle, nandDqOe}, 6'b111000);
    chk(reqReady && !rdValid && !resValid, "R1", "handshakes after reset",
        {reqReady, rdValid, resValid}, 3'b100);

    // R3 read sweep: three areas x three lengths
    for (int a = 0; a < 3; a++)
      for (int l = 0; l < 3; l++)
        doRead(a, 8'h10 + a * 37, 16'h1234 + a * 16'h0401 + l, (l == 0) ? 1 : (l == 1) ? 5 : 528, 0);
    doRead(3, 8'h05, 16'hBEEF, 7, 0);
    // R3 clamp above page size
    doRead(0, 8'h00, 16'h0042, 600, 0);
    // R9 backpressure
    doRead(1, 8'h33, 16'h7001, 40, 1);

    // R4 program sweep
    for (int l = 0; l < 3; l++)
      for (int s = 0; s < 2; s++) begin
        int len = (l == 0) ? 1 : (l == 1) ? 4 : 528;
        statusVal = s ? 8'hE1 : 8'hE0;
        runOp(1, 0, 8'h20 + l, 16'h0300 + l * 16'h0111, len, 0, 3 + l);
        push(0, 8'h80); push(1, 8'(8'h20 + l));
        push(1, 8'(16'h0300 + l * 16'h0111)); push(1, 8'((16'h0300 + l * 16'h0111) >> 8));
        for (int i = 0; i < len; i++) push(2, 8'(i * 11 + 3 + l));
        push(0, 8'h10); push(0, 8'h70);
        chkSeq("R4");
        doStatusTail("R4", statusVal);
      end

    // R5 erase
    for (int s = 0; s < 2; s++) begin
      statusVal = s ? 8'hC1 : 8'hC0;
      runOp(2, 0, 8'hAA, 16'h5A3C + s, 0, 0, 0);
      push(0, 8'h60); push(1, 8'(16'h5A3C + s)); push(1, 8'h5A); push(0, 8'hD0); push(0, 8'h70);
      chkSeq("R5");
      doStatusTail("R5", statusVal);
    end

    // R6 status sweep, including out-of-range opcodes
    for (int v = 0; v < 16; v++) begin
      statusVal = 8'(v * 17);
      runOp((v < 13) ? 3 : v - 8, 0, 0, 0, 0, 0, 0);
      push(0, 8'h70);
      chkSeq("R6");
      chk(gStat == statusVal && gFail == statusVal[0], "R6", "status result", gStat, statusVal);
    end

    // R7 identification: good, bad second, bad first
    for (int k = 0; k < 3; k++) begin
      idB0 = (k == 2) ? 8'h98 : 8'hEC;
      idB1 = (k == 1) ? 8'h74 : 8'h73;
      runOp(4, 0, 8'h55, 16'hFFFF, 0, 0, 0);
      push(0, 8'h90); push(1, 8'h00);
      chkSeq("R7");
      chk(rdN == 2 && rdBuf[0] == idB0 && rdBuf[1] == idB1, "R7", "id bytes streamed", rdN, 2);
      chk(gFail == (k != 0), "R7", "id mismatch flag", gFail, k != 0);
    end
    idB0 = 8'hEC; idB1 = 8'h73;

    // R8 busy never ends
    busyLong = 1;
    runOp(1, 0, 8'h01, 16'h0002, 2, 0, 9);
    push(0, 8'h80); push(1, 8'h01); push(1, 8'h02); push(1, 8'h00);
    push(2, 8'(9)); push(2, 8'(20)); push(0, 8'h10);
    chkSeq("R8");
    chk(gFail && gTmo, "R8", "timeout result", {gFail, gTmo}, 2'b11);
    chk(nandCeN, "R8", "chip enable released", nandCeN, 1);
    busyLong = 0; bLow = 2;
    repeat (5) @(negedge clk);

    chk(phaseErr == 0, "R2", "strobe low width and bus drive", phaseErr, 0);
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule